// File: doc/BRIEF.md
# Eight-bit Accumulator ALU with Status Flags

This block is the datapath heart of a small accumulator-style processor. It takes a working-register byte and a second byte (either a value fetched from the register file or an immediate), applies one of seventeen arithmetic, logic, rotate, nibble-swap or decimal-adjust operations, and presents the 8-bit result in the same cycle. Five status flags (carry, digit carry, zero, overflow, negative) live in a register inside the block. On each accepted operation, only the flags that the operation is defined to touch are rewritten. The carry flag also feeds back as an input to carry-aware operations.

A one-bit destination select picks where the result should go: the working register or the file location the second operand came from. The block raises exactly one write strobe for that target. The instruction decoder around the block supplies the operation code, the operands and the destination bit. Memory and the multiplier are handled elsewhere.

Top module: `acc_alu8`

## Requirements
- R1: When `rst` is high at a rising clock edge, `status` becomes 0 at that edge. Bit layout of `status`: [0]=C carry, [1]=DC digit carry, [2]=Z zero, [3]=OV overflow, [4]=N negative.
- R2: The add/subtract operations compute `result` = (A + B + cin) mod 256 and set C to the carry out of bit 7. The operand sets are: ADD=0 (A=f, B=w, cin=0), SUB=2 (A=f, B=~w, cin=1), INC=4 (A=f, B=0, cin=1), DEC=5 (A=f, B=0xFF, cin=0), NEG=6 (A=0, B=~f, cin=1). For subtraction, C=1 therefore means that no borrow occurred.
- R3: For the operations of R2 and R6, DC is the carry out of the low-nibble sum A[3:0] + B[3:0] + cin.
- R4: For the operations of R2 and R6, OV is 1 exactly when A[7] equals B[7] and result[7] differs from them.
- R5: Every legal operation sets Z to (result == 0) and N to result[7].
- R6: ADDC=1 and SUBB=3 behave as ADD and SUB, except that cin is the C flag held in `status` before the operation.
- R7: The rotates act on f. RLC=11 gives {f[6:0],C}, and C takes f[7]. RRC=13 gives {C,f[7:1]}, and C takes f[0]. RLN=12 gives {f[6:0],f[7]}. RRN=14 gives {f[0],f[7:1]}. RLN and RRN leave C unchanged. All four rotates leave DC and OV unchanged.
- R8: COM=7 (~f), AND=8, IOR=9, XOR=10 (w combined with f) and SWAP=15 ({f[3:0],f[7:4]}) change only Z and N.
- R9: DAW=16 works on w. Step one adds 6 when w[3:0] > 9 or DC=1. Step two then adds 0x60 when the step-one sum has a high nibble above 9, or carried out, or C=1. C becomes 1 if step two was applied and 0 otherwise. DC and OV are kept.
- R10: For a legal accepted operation, `wr_work` is high when `dest_sel`=0 and `wr_file` is high when `dest_sel`=1. DAW always raises `wr_work` only. The two strobes are never high together.
- R11: With `op_valid` low, or with an op code of 17 to 31, both strobes stay low and `status` is left unchanged.
- R12: ADD with f=0x9F and w=0x52 gives 0xF1 with N=1, OV=0, Z=0, C=0, DC=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 5 | Operation select (codes 0 to 16) |
| dest_sel | input | 1 | 0: result to working register, 1: result to file operand |
| w_opnd | input | 8 | Working-register operand |
| f_opnd | input | 8 | File-register or literal operand |
| result | output | 8 | Combinational operation result |
| wr_work | output | 1 | Write strobe for the working register |
| wr_file | output | 1 | Write strobe for the file location |
| status | output | 5 | Registered flags {N,OV,Z,DC,C} |

## Verification
The sweep presets every combination of C and DC before each operation and runs every working-register value against a spread of file values. Three kinds of fault are the main targets, and each would show up as a wrong flag. A carry-in taken from the wrong place would make ADDC and SUBB results differ by one. A subtraction carry with inverted sense would make C read as a borrow. A DAW that tests the high nibble before the low correction would miss cases such as 0x9A, where the low correction pushes the high nibble past 9. Other checks target flag masking: logic or non-carry rotate operations that overwrite C, DC or OV would corrupt later carry-aware operations. Idle cycles and undefined codes must leave the flags and strobes alone.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OPC_W  = 5;
  localparam int NFLAGS = 5;
  localparam int FLG_C  = 0;
  localparam int FLG_DC = 1;
  localparam int FLG_Z  = 2;
  localparam int FLG_OV = 3;
  localparam int FLG_N  = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD  = 5'd0,  OP_ADDC = 5'd1,  OP_SUB  = 5'd2,  OP_SUBB = 5'd3,
    OP_INC  = 5'd4,  OP_DEC  = 5'd5,  OP_NEG  = 5'd6,  OP_COM  = 5'd7,
    OP_AND  = 5'd8,  OP_IOR  = 5'd9,  OP_XOR  = 5'd10, OP_RLC  = 5'd11,
    OP_RLN  = 5'd12, OP_RRC  = 5'd13, OP_RRN  = 5'd14, OP_SWAP = 5'd15,
    OP_DAW  = 5'd16
  } alu_op_e;

  // which flags an operation rewrites
  function automatic logic [NFLAGS-1:0] flag_mask(input alu_op_e op);
    logic [NFLAGS-1:0] m;
    m = '0;
    case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBB, OP_INC, OP_DEC, OP_NEG:
        m = '1;
      OP_RLC, OP_RRC, OP_DAW: begin
        m[FLG_C] = 1'b1; m[FLG_Z] = 1'b1; m[FLG_N] = 1'b1;
      end
      OP_COM, OP_AND, OP_IOR, OP_XOR, OP_SWAP, OP_RLN, OP_RRN: begin
        m[FLG_Z] = 1'b1; m[FLG_N] = 1'b1;
      end
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic              c_in,
  output logic [DATA_W-1:0] sum,
  output logic              c_out,
  output logic              dc_out,
  output logic              ov_out
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W:0] full;
  logic [HALF:0]   low;

  always_comb begin
    full   = {1'b0, a_in} + {1'b0, b_in} + {{DATA_W{1'b0}}, c_in};
    low    = {1'b0, a_in[HALF-1:0]} + {1'b0, b_in[HALF-1:0]} + {{HALF{1'b0}}, c_in};
    sum    = full[DATA_W-1:0];
    c_out  = full[DATA_W];
    dc_out = low[HALF];
    ov_out = (a_in[DATA_W-1] == b_in[DATA_W-1]) && (full[DATA_W-1] != a_in[DATA_W-1]);
  end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops import alu8_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] w_in,
  input  logic [DATA_W-1:0] f_in,
  input  logic              c_in,
  output logic [DATA_W-1:0] res,
  output logic              c_out
);
  localparam int HALF = DATA_W / 2;

  always_comb begin
    res   = f_in;
    c_out = c_in;
    case (op)
      OP_COM:  res = ~f_in;
      OP_AND:  res = w_in & f_in;
      OP_IOR:  res = w_in | f_in;
      OP_XOR:  res = w_in ^ f_in;
      OP_SWAP: res = {f_in[HALF-1:0], f_in[DATA_W-1:HALF]};
      OP_RLN:  res = {f_in[DATA_W-2:0], f_in[DATA_W-1]};
      OP_RRN:  res = {f_in[0], f_in[DATA_W-1:1]};
      OP_RLC: begin
        res   = {f_in[DATA_W-2:0], c_in};
        c_out = f_in[DATA_W-1];
      end
      OP_RRC: begin
        res   = {c_in, f_in[DATA_W-1:1]};
        c_out = f_in[0];
      end
      default: begin
        res   = f_in;
        c_out = c_in;
      end
    endcase
  end
endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] w_in,
  input  logic              c_in,
  input  logic              dc_in,
  output logic [DATA_W-1:0] res,
  output logic              c_out
);
  localparam int HALF = DATA_W / 2;
  localparam logic [DATA_W:0]   LO_FIX = (DATA_W+1)'(6);
  localparam logic [DATA_W-1:0] HI_FIX = DATA_W'(6) << HALF;

  logic            lo_corr;
  logic            hi_corr;
  logic [DATA_W:0] step1;

  always_comb begin
    lo_corr = (w_in[HALF-1:0] > HALF'(9)) || dc_in;
    step1   = {1'b0, w_in} + (lo_corr ? LO_FIX : '0);
    hi_corr = c_in || step1[DATA_W] || (step1[DATA_W-1:HALF] > (DATA_W-HALF)'(9));
    res     = step1[DATA_W-1:0] + (hi_corr ? HI_FIX : '0);
    c_out   = hi_corr;
  end
endmodule

// File: rtl/acc_alu8.sv
module acc_alu8 import alu8_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [OPC_W-1:0]  op_code,
  input  logic              dest_sel,
  input  logic [DATA_W-1:0] w_opnd,
  input  logic [DATA_W-1:0] f_opnd,
  output logic [DATA_W-1:0] result,
  output logic              wr_work,
  output logic              wr_file,
  output logic [NFLAGS-1:0] status
);
  alu_op_e           op_e;
  logic              legal;
  logic              upd;
  logic [NFLAGS-1:0] mask;
  logic [NFLAGS-1:0] next_flags;

  logic [DATA_W-1:0] add_a, add_b, add_sum;
  logic              add_ci, add_c, add_dc, add_ov, is_arith;
  logic [DATA_W-1:0] bit_res, dec_res;
  logic              bit_c, dec_c;

  assign op_e  = alu_op_e'(op_code);
  assign legal = (int'(op_code) <= int'(OP_DAW));
  assign upd   = op_valid && legal;
  assign mask  = flag_mask(op_e);

  // operand steering for the shared adder
  always_comb begin
    add_a    = f_opnd;
    add_b    = w_opnd;
    add_ci   = 1'b0;
    is_arith = 1'b1;
    case (op_e)
      OP_ADD:  ;
      OP_ADDC: add_ci = status[FLG_C];
      OP_SUB:  begin add_b = ~w_opnd; add_ci = 1'b1; end
      OP_SUBB: begin add_b = ~w_opnd; add_ci = status[FLG_C]; end
      OP_INC:  begin add_b = '0; add_ci = 1'b1; end
      OP_DEC:  add_b = '1;
      OP_NEG:  begin add_a = '0; add_b = ~f_opnd; add_ci = 1'b1; end
      default: is_arith = 1'b0;
    endcase
  end

  alu8_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_in(add_a), .b_in(add_b), .c_in(add_ci),
    .sum(add_sum), .c_out(add_c), .dc_out(add_dc), .ov_out(add_ov)
  );

  alu8_bitops #(.DATA_W(DATA_W)) u_bitops (
    .op(op_e), .w_in(w_opnd), .f_in(f_opnd), .c_in(status[FLG_C]),
    .res(bit_res), .c_out(bit_c)
  );

  alu8_decadj #(.DATA_W(DATA_W)) u_decadj (
    .w_in(w_opnd), .c_in(status[FLG_C]), .dc_in(status[FLG_DC]),
    .res(dec_res), .c_out(dec_c)
  );

  always_comb begin
    if (is_arith)            result = add_sum;
    else if (op_e == OP_DAW) result = dec_res;
    else                     result = bit_res;
    next_flags         = status;
    next_flags[FLG_C]  = is_arith ? add_c : ((op_e == OP_DAW) ? dec_c : bit_c);
    next_flags[FLG_DC] = add_dc;
    next_flags[FLG_OV] = add_ov;
    next_flags[FLG_Z]  = (result == '0);
    next_flags[FLG_N]  = result[DATA_W-1];
  end

  assign wr_work = upd && (!dest_sel || op_e == OP_DAW);
  assign wr_file = upd && dest_sel && op_e != OP_DAW;

  // one register per flag, each with its own update enable
  for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                 status[g] <= 1'b0;
      else if (upd && mask[g]) status[g] <= next_flags[g];
    end
  end

  logic [DATA_W:0] chk_add9;
  assign chk_add9 = {1'b0, w_opnd} + {1'b0, f_opnd};

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> status == '0);

  p_add_carry_r2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 5'(OP_ADD)) |=> status[FLG_C] == $past(chk_add9[DATA_W]));

  p_zero_flag_r5: assert property (@(posedge clk) disable iff (rst)
    upd |=> status[FLG_Z] == ($past(result) == '0));

  p_neg_flag_r5: assert property (@(posedge clk) disable iff (rst)
    upd |=> status[FLG_N] == $past(result[DATA_W-1]));

  p_logic_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == 5'(OP_AND) || op_code == 5'(OP_IOR) ||
                  op_code == 5'(OP_XOR) || op_code == 5'(OP_COM) ||
                  op_code == 5'(OP_SWAP)))
    |=> ($stable(status[FLG_C]) && $stable(status[FLG_DC]) && $stable(status[FLG_OV])));

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_work, wr_file}) && ((wr_work || wr_file) == upd));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(status));
endmodule

// File: tb/test_acc_alu8.sv
module test_acc_alu8;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       op_valid;
  logic [4:0] op_code;
  logic       dest_sel;
  logic [7:0] w_opnd, f_opnd;
  logic [7:0] result;
  logic       wr_work, wr_file;
  logic [4:0] status;

  int n_tests = 0;
  int n_fail  = 0;
  logic [4:0] cur_flags;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu8 i_acc_alu8 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .dest_sel(dest_sel), .w_opnd(w_opnd), .f_opnd(f_opnd),
    .result(result), .wr_work(wr_work), .wr_file(wr_file), .status(status)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected {result, flags} from the requirement text
  function automatic logic [12:0] model(input int oc, input logic [7:0] w, input logic [7:0] f,
                                        input logic [4:0] fl);
    logic [7:0] r, a, b;
    logic [4:0] nf;
    int ci, s, t;
    logic lo, hi;
    nf = fl; r = 8'h00; a = 8'h00; b = 8'h00; ci = 0;
    if (oc <= 6) begin
      case (oc)
        0: begin a = f; b = w; ci = 0; end
        1: begin a = f; b = w; ci = int'(fl[0]); end
        2: begin a = f; b = ~w; ci = 1; end
        3: begin a = f; b = ~w; ci = int'(fl[0]); end
        4: begin a = f; b = 8'h00; ci = 1; end
        5: begin a = f; b = 8'hFF; ci = 0; end
        default: begin a = 8'h00; b = ~f; ci = 1; end
      endcase
      s = int'(a) + int'(b) + ci;
      r = s[7:0];
      nf[0] = (s > 255);
      nf[1] = ((int'(a[3:0]) + int'(b[3:0]) + ci) > 15);
      nf[3] = (a[7] == b[7]) && (r[7] != a[7]);
    end else begin
      case (oc)
        7:  r = ~f;
        8:  r = w & f;
        9:  r = w | f;
        10: r = w ^ f;
        11: begin r = {f[6:0], fl[0]}; nf[0] = f[7]; end
        12: r = {f[6:0], f[7]};
        13: begin r = {fl[0], f[7:1]}; nf[0] = f[0]; end
        14: r = {f[0], f[7:1]};
        15: r = {f[3:0], f[7:4]};
        16: begin
          lo = (w[3:0] > 4'd9) || fl[1];
          t  = int'(w) + (lo ? 6 : 0);
          hi = fl[0] || (t > 255) || (((t >> 4) & 15) > 9);
          t  = t + (hi ? 96 : 0);
          r  = t[7:0];
          nf[0] = hi;
        end
        default: r = 8'h00;
      endcase
    end
    if (oc <= 16) begin
      nf[2] = (r == 8'h00);
      nf[4] = r[7];
    end
    return {r, nf};
  endfunction

  function automatic string req_tag(input int oc);
    if (oc == 1 || oc == 3) return "R6";
    if (oc <= 6)  return "R2";
    if (oc == 11 || oc == 12 || oc == 13 || oc == 14) return "R7";
    if (oc == 16) return "R9";
    if (oc <= 15) return "R8";
    return "R11";
  endfunction

  // one operation per clock; chk enables the result and strobe checks
  task automatic run_op(input int oc, input logic [7:0] w, input logic [7:0] f,
                        input logic d, input logic v, input bit chk);
    logic [12:0] m;
    logic legal, ew, ef;
    @(negedge clk);
    op_valid = v; op_code = 5'(oc); w_opnd = w; f_opnd = f; dest_sel = d;
    #1;
    legal = (oc <= 16) && v;
    m  = model(oc, w, f, cur_flags);
    ew = legal && (!d || oc == 16);
    ef = legal && d && oc != 16;
    if (chk) begin
      if (legal) check(result == m[12:5], req_tag(oc), int'(result), int'(m[12:5]));
      check({wr_work, wr_file} == {ew, ef}, legal ? "R10 strobes" : "R11 strobes",
            int'({wr_work, wr_file}), int'({ew, ef}));
    end
    if (legal) cur_flags = m[4:0];
    @(posedge clk); #1;
    if (chk)
      check(status == cur_flags, legal ? {req_tag(oc), " R3 R4 R5 flags"} : "R11 flags",
            int'(status), int'(cur_flags));
  endtask

  task automatic preset(input int sel);
    case (sel)
      0: run_op(0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
      1: run_op(0, 8'hF0, 8'h10, 1'b0, 1'b1, 1'b0);
      2: run_op(0, 8'h0F, 8'h01, 1'b0, 1'b1, 1'b0);
      default: run_op(0, 8'hFF, 8'h01, 1'b0, 1'b1, 1'b0);
    endcase
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; op_valid = 1'b0; op_code = '0; dest_sel = 1'b0;
    w_opnd = '0; f_opnd = '0; cur_flags = '0;
    repeat (3) @(posedge clk);
    #1;
    check(status == 5'd0, "R1 reset", int'(status), 0);
    @(negedge clk); rst = 1'b0;

    // R12 worked example: flags {N,OV,Z,DC,C} = 1,0,0,1,0
    preset(3);
    run_op(0, 8'h52, 8'h9F, 1'b0, 1'b1, 1'b1);
    check(result == 8'hF1, "R12 result", int'(result), 8'hF1);
    check(status == 5'b10010, "R12 flags", int'(status), 5'b10010);

    // R11: idle cycles and undefined codes leave flags and strobes alone
    preset(3);
    run_op(0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1);
    run_op(2, 8'h55, 8'hAA, 1'b0, 1'b0, 1'b1);
    for (int oc = 17; oc < 32; oc++) run_op(oc, 8'h12, 8'h00, 1'b1, 1'b1, 1'b1);

    // near-exhaustive sweep: all ops, all w values, four C/DC presets
    for (int oc = 0; oc <= 16; oc++)
      for (int wi = 0; wi < 16; wi++)
        for (int bi = 0; bi < 32; bi++)
          for (int cf = 0; cf < 4; cf++) begin
            logic [7:0] w, f;
            w = 8'((wi * 16 + bi) & 255);
            f = 8'((bi * 8 + wi * 5 + cf * 3) & 255);
            preset(cf);
            run_op(oc, w, f, w[0] ^ f[3], 1'b1, 1'b1);
          end

    // R1 again: reset in mid-run clears flags set by earlier work
    preset(3);
    @(negedge clk); rst = 1'b1; op_valid = 1'b0;
    @(posedge clk); #1;
    check(status == 5'd0, "R1 reset mid-run", int'(status), 0);
    @(negedge clk); rst = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule